// File: doc/BRIEF.md
# Processor Status Flag Unit

This unit holds the status bits of an 8-bit processor core and updates them. On each arithmetic step the core presents the two operand bytes and the operation kind, which is add or subtract. When the flag write strobe is high, the unit records three things: the signed overflow, the carry or borrow out of the top bit, and the carry or borrow between the low nibble and the high nibble.

The unit also holds the interrupt-enable bit. It is a two-state machine. Enable and disable strobes drive it, and an interrupt-acknowledge pulse clears it. A combinational acceptance gate uses that bit to decide which pending requests the core may take:
- A non-maskable request is always taken.
- An automatic transfer-service request is taken whenever its own mask bit is clear, whatever the enable bit says.
- A normal maskable request is taken only when enable is set and its mask bit is clear.

A register-bank select bit tells the register file which physical bank serves as the working registers. Priority resolution among requests is done elsewhere.

The enable machine has two states. IEN_OFF is entered at reset. IEN_ON is reached from IEN_OFF by transition T_ENABLE (enable strobe alone). IEN_ON returns to IEN_OFF by T_DISABLE (disable strobe) or T_ACK (acknowledge). In every other case each state holds (T_HOLD).

Top module: `psw_unit`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, clears flag_pv, flag_ac, flag_cy, flag_ie and flag_rss to 0 after that edge.
- R2: With op_sub=0 and flag_we=1, after the clock edge flag_cy holds the carry out of bit 7 of op_a+op_b, and flag_pv is 1 exactly when the signed sum lies outside −128..+127. For example, 78H+69H gives pv=1, cy=0, and FBH+F0H gives pv=0, cy=1.
- R3: With op_sub=1 and flag_we=1, after the clock edge flag_cy is 1 exactly when op_a < op_b (unsigned borrow), and flag_pv is 1 exactly when the signed difference op_a−op_b lies outside −128..+127.
- R4: With flag_we=1, flag_ac becomes 1 when an add carries out of bit 3, or when a subtract borrows into bit 3 (op_a[3:0] < op_b[3:0]), and becomes 0 otherwise.
- R5: With flag_we=0, flag_pv, flag_ac and flag_cy keep their values whatever the operands are.
- R6: ei_stb alone sets flag_ie on the next edge, and di_stb clears it.
- R7: int_ack clears flag_ie on the next edge and wins over ei_stb in the same cycle. di_stb also wins over ei_stb.
- R8: take_nmi equals nmi_req, and take_xfer equals xfer_req AND NOT xfer_mask, in the same cycle and regardless of flag_ie.
- R9: take_mask equals mreq AND NOT mmask AND flag_ie in the same cycle.
- R10: flag_rss takes rss_d on an edge where rss_we=1 and otherwise holds its value. Bank 0 is selected when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 8 | First operand (minuend for subtract) |
| op_b | input | 8 | Second operand (subtrahend for subtract) |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| flag_we | input | 1 | Write the arithmetic flags this cycle |
| ei_stb | input | 1 | Enable interrupts |
| di_stb | input | 1 | Disable interrupts |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| rss_we | input | 1 | Write the bank select bit |
| rss_d | input | 1 | New bank select value |
| mreq | input | 1 | Maskable interrupt request |
| mmask | input | 1 | Mask bit of the maskable request |
| nmi_req | input | 1 | Non-maskable request |
| xfer_req | input | 1 | Automatic transfer-service request |
| xfer_mask | input | 1 | Mask bit of the transfer-service request |
| flag_pv | output | 1 | Signed overflow flag |
| flag_ac | output | 1 | Nibble carry/borrow flag |
| flag_cy | output | 1 | Carry/borrow flag |
| flag_ie | output | 1 | Interrupt enable flag |
| flag_rss | output | 1 | Register bank select |
| take_mask | output | 1 | Maskable request may be taken |
| take_nmi | output | 1 | Non-maskable request may be taken |
| take_xfer | output | 1 | Transfer-service request may be taken |

## Verification
The hardest cases to reach are the collisions on the enable bit. An acknowledge or a disable that lands in the same cycle as an enable strobe must leave the machine in IEN_OFF. A random stream seldom produces these while the machine is in the matching state. The stimulus therefore first drives the machine into IEN_ON and IEN_OFF with directed strobes, then fires the colliding pairs from each state. Signed overflow on subtraction is reached with hand-picked operands whose signs differ, such as 80H−01H and 7FH−FFH. Random operands then sweep the nibble borrow and carry cases.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic {
        IEN_OFF = 1'b0,
        IEN_ON  = 1'b1
    } ien_state_e;

    typedef struct packed {
        logic pv;
        logic ac;
        logic cy;
    } arith_flags_t;

endpackage

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
    import psw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output arith_flags_t      nxt
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] full;
    logic [MSB:0]    low;
    logic [NIB_W:0]  nib;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b};
            low  = {1'b0, a[MSB-1:0]} - {1'b0, b[MSB-1:0]};
            nib  = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]};
        end else begin
            full = {1'b0, a} + {1'b0, b};
            low  = {1'b0, a[MSB-1:0]} + {1'b0, b[MSB-1:0]};
            nib  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]};
        end
        nxt.cy = full[DATA_W];
        nxt.pv = low[MSB] ^ full[DATA_W];
        nxt.ac = nib[NIB_W];
    end
endmodule

// File: rtl/psw_ien_fsm.sv
module psw_ien_fsm
    import psw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ei,
    input  logic di,
    input  logic ack,
    output logic ie
);
    ien_state_e state_q, state_d;
    logic       drop;

    assign drop = di | ack;

    always_ff @(posedge clk) begin
        if (rst) state_q <= IEN_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IEN_OFF: if (ei && !drop) state_d = IEN_ON;
            IEN_ON:  if (drop)        state_d = IEN_OFF;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IEN_OFF: ie = 1'b0;
            IEN_ON:  ie = 1'b1;
        endcase
    end
endmodule

// File: rtl/psw_accept_gate.sv
module psw_accept_gate (
    input  logic ie,
    input  logic mreq,
    input  logic mmask,
    input  logic nmi_req,
    input  logic xfer_req,
    input  logic xfer_mask,
    output logic take_mask,
    output logic take_nmi,
    output logic take_xfer
);
    always_comb begin
        take_nmi  = nmi_req;
        take_xfer = xfer_req & ~xfer_mask;
        take_mask = ie & mreq & ~mmask;
    end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
    import psw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              op_sub,
    input  logic              flag_we,
    input  logic              ei_stb,
    input  logic              di_stb,
    input  logic              int_ack,
    input  logic              rss_we,
    input  logic              rss_d,
    input  logic              mreq,
    input  logic              mmask,
    input  logic              nmi_req,
    input  logic              xfer_req,
    input  logic              xfer_mask,
    output logic              flag_pv,
    output logic              flag_ac,
    output logic              flag_cy,
    output logic              flag_ie,
    output logic              flag_rss,
    output logic              take_mask,
    output logic              take_nmi,
    output logic              take_xfer
);
    arith_flags_t calc_d, flags_q;
    logic         rss_q;

    psw_flag_calc #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_calc (
        .a   (op_a),
        .b   (op_b),
        .sub (op_sub),
        .nxt (calc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            rss_q   <= 1'b0;
        end else begin
            if (flag_we) flags_q <= calc_d;
            if (rss_we)  rss_q   <= rss_d;
        end
    end

    psw_ien_fsm u_ien (
        .clk (clk),
        .rst (rst),
        .ei  (ei_stb),
        .di  (di_stb),
        .ack (int_ack),
        .ie  (flag_ie)
    );

    psw_accept_gate u_gate (
        .ie        (flag_ie),
        .mreq      (mreq),
        .mmask     (mmask),
        .nmi_req   (nmi_req),
        .xfer_req  (xfer_req),
        .xfer_mask (xfer_mask),
        .take_mask (take_mask),
        .take_nmi  (take_nmi),
        .take_xfer (take_xfer)
    );

    assign flag_pv  = flags_q.pv;
    assign flag_ac  = flags_q.ac;
    assign flag_cy  = flags_q.cy;
    assign flag_rss = rss_q;
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk (
    input logic clk,
    input logic rst,
    input logic flag_we,
    input logic ei_stb,
    input logic di_stb,
    input logic int_ack,
    input logic rss_we,
    input logic mreq,
    input logic mmask,
    input logic nmi_req,
    input logic flag_pv,
    input logic flag_ac,
    input logic flag_cy,
    input logic flag_ie,
    input logic flag_rss,
    input logic take_mask,
    input logic take_nmi
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !(flag_pv || flag_ac || flag_cy || flag_ie || flag_rss));

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable({flag_pv, flag_ac, flag_cy}));

    // R6
    ien_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ei_stb && !di_stb && !int_ack) |=> flag_ie);

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (int_ack || di_stb) |=> !flag_ie);

    // R8
    nmi_pass_chk: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> take_nmi);

    // R9
    mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
        take_mask |-> (flag_ie && mreq && !mmask));

    // R10
    rss_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rss_we |=> $stable(flag_rss));
endmodule

bind psw_unit psw_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .flag_we   (flag_we),
    .ei_stb    (ei_stb),
    .di_stb    (di_stb),
    .int_ack   (int_ack),
    .rss_we    (rss_we),
    .mreq      (mreq),
    .mmask     (mmask),
    .nmi_req   (nmi_req),
    .flag_pv   (flag_pv),
    .flag_ac   (flag_ac),
    .flag_cy   (flag_cy),
    .flag_ie   (flag_ie),
    .flag_rss  (flag_rss),
    .take_mask (take_mask),
    .take_nmi  (take_nmi)
);

// File: tb/psw_unit_test.sv
`timescale 1ns/1ps
module psw_unit_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] op_a, op_b;
    logic       op_sub, flag_we, ei_stb, di_stb, int_ack, rss_we, rss_d;
    logic       mreq, mmask, nmi_req, xfer_req, xfer_mask;
    logic       flag_pv, flag_ac, flag_cy, flag_ie, flag_rss;
    logic       take_mask, take_nmi, take_xfer;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    int m_pv, m_ac, m_cy, m_ie, m_rss;
    string last_flag_tag;

    always #2.5 clk = ~clk;

    psw_unit uut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
        .flag_we(flag_we), .ei_stb(ei_stb), .di_stb(di_stb), .int_ack(int_ack),
        .rss_we(rss_we), .rss_d(rss_d), .mreq(mreq), .mmask(mmask),
        .nmi_req(nmi_req), .xfer_req(xfer_req), .xfer_mask(xfer_mask),
        .flag_pv(flag_pv), .flag_ac(flag_ac), .flag_cy(flag_cy),
        .flag_ie(flag_ie), .flag_rss(flag_rss), .take_mask(take_mask),
        .take_nmi(take_nmi), .take_xfer(take_xfer)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int sgn(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // one cycle: check gates, advance model at the edge, check registers
    task automatic tick();
        string ftag, itag;
        int    s;
        #1;
        cmp("R8", "take_nmi", take_nmi, nmi_req);
        cmp("R8", "take_xfer", take_xfer, xfer_req && !xfer_mask);
        cmp("R9", "take_mask", take_mask, m_ie && mreq && !mmask);
        @(posedge clk);
        if (rst) begin
            m_pv = 0; m_ac = 0; m_cy = 0; m_ie = 0; m_rss = 0;
            ftag = "R1"; itag = "R1";
        end else begin
            if (flag_we) begin
                if (op_sub) begin
                    m_cy = (op_a < op_b) ? 1 : 0;
                    s    = sgn(op_a) - sgn(op_b);
                    m_ac = ((op_a % 16) < (op_b % 16)) ? 1 : 0;
                    ftag = "R3";
                end else begin
                    m_cy = (int'(op_a) + int'(op_b) > 255) ? 1 : 0;
                    s    = sgn(op_a) + sgn(op_b);
                    m_ac = ((op_a % 16) + (op_b % 16) > 15) ? 1 : 0;
                    ftag = "R2";
                end
                m_pv = (s > 127 || s < -128) ? 1 : 0;
            end else begin
                ftag = "R5";
            end
            if (int_ack || di_stb) begin
                m_ie = 0; itag = "R7";
            end else if (ei_stb) begin
                m_ie = 1; itag = "R6";
            end else begin
                itag = "R6";
            end
            if (rss_we) m_rss = rss_d;
        end
        @(negedge clk);
        cmp(ftag, "flag_pv", flag_pv, m_pv);
        cmp(ftag, "flag_cy", flag_cy, m_cy);
        cmp((ftag == "R5" || ftag == "R1") ? ftag : "R4", "flag_ac", flag_ac, m_ac);
        cmp(itag, "flag_ie", flag_ie, m_ie);
        cmp((rst) ? "R1" : "R10", "flag_rss", flag_rss, m_rss);
    endtask

    task automatic idle();
        rst = 0; flag_we = 0; ei_stb = 0; di_stb = 0; int_ack = 0;
        rss_we = 0; rss_d = 0; mreq = 0; mmask = 0; nmi_req = 0;
        xfer_req = 0; xfer_mask = 0; op_sub = 0; op_a = 0; op_b = 0;
    endtask

    task automatic arith(input int a, input int b, input bit sub);
        idle(); op_a = a[7:0]; op_b = b[7:0]; op_sub = sub; flag_we = 1; tick();
    endtask

    initial begin
        m_pv = 0; m_ac = 0; m_cy = 0; m_ie = 0; m_rss = 0;
        idle(); rst = 1;
        @(negedge clk);
        tick(); tick();                                   // R1 reset state
        arith(8'h78, 8'h69, 0);                           // R2 pv=1 cy=0
        arith(8'hFB, 8'hF0, 0);                           // R2 pv=0 cy=1
        arith(8'h0F, 8'h01, 0);                           // R4 nibble carry
        arith(8'h80, 8'h01, 1);                           // R3 signed overflow
        arith(8'h7F, 8'hFF, 1);                           // R3 overflow + borrow
        arith(8'h10, 8'h01, 1);                           // R4 nibble borrow
        idle(); op_a = 8'hFF; op_b = 8'hFF; tick();       // R5 hold
        idle(); ei_stb = 1; tick();                       // R6 enable
        idle(); mreq = 1; tick();                         // R9 taken
        idle(); mreq = 1; mmask = 1; tick();              // R9 masked
        idle(); ei_stb = 1; int_ack = 1; tick();          // R7 ack wins from IEN_ON
        idle(); ei_stb = 1; int_ack = 1; tick();          // R7 ack wins from IEN_OFF
        idle(); ei_stb = 1; di_stb = 1; tick();           // R7 di wins
        idle(); mreq = 1; nmi_req = 1; xfer_req = 1; tick(); // R8 with ie=0
        idle(); xfer_req = 1; xfer_mask = 1; tick();      // R8 masked transfer
        idle(); rss_we = 1; rss_d = 1; tick();            // R10 write
        idle(); rss_d = 0; tick();                        // R10 hold
        idle(); ei_stb = 1; tick();
        idle(); di_stb = 1; tick();                       // R6 disable
        for (int i = 0; i < 400; i++) begin
            idle();
            op_a = 8'($urandom); op_b = 8'($urandom);
            op_sub = 1'($urandom); flag_we = ($urandom % 3) != 0;
            ei_stb = ($urandom % 3) == 0; di_stb = ($urandom % 5) == 0;
            int_ack = ($urandom % 5) == 0; rss_we = ($urandom % 4) == 0;
            rss_d = 1'($urandom); mreq = 1'($urandom); mmask = 1'($urandom);
            nmi_req = 1'($urandom); xfer_req = 1'($urandom); xfer_mask = 1'($urandom);
            rst = ($urandom % 50) == 0;
            tick();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule